// File: doc/BRIEF.md
# Double-Buffered Compare Timer

This block is an up counter with a compare register that produces a one-cycle match strobe and a one-cycle overflow strobe. Three counting modes are available. In interval mode the counter runs across the full word and restarts after a match. In pulse-width mode the counter wraps every 2^n counts, with n chosen from a small set. In pulse-pair mode the counter restarts when it reaches a separate period register.

Software writes compare values through a single write strobe that reaches both the compare register and a staging buffer. While the staging enable is low, a write updates both at once. While it is high, a write lands only in the staging buffer. The compare register then takes the staged value at the end of a pulse-width or pulse-pair cycle, so the compare point never changes part-way through a cycle. Interval mode has no cycle end, so staged values are never loaded there.

Top module: `dbuf_cmp_timer`

## Requirements
- R1: After reset the count is 0, the compare register and staging buffer are 0, the period register is all ones, and match and ovf are low.
- R2: When cnt_en is high and the compare value is nonzero, match is high for exactly the cycles in which count equals the compare value.
- R3: When the compare value is 0, match is high in the same cycle as ovf and never because count is 0.
- R4: A write (wr_cmp) while dbuf_en is 0 sets both the compare register and the staging buffer to wr_data. The new value shows on cmp_value in the next cycle.
- R5: A write while dbuf_en is 1 changes only the staging buffer. cmp_value keeps its value until a transfer happens.
- R6: In pulse-width mode (mode 2'b01), n is 6, 7 or 8 for pwm_sel 0, 1 or 2 (3 also gives 8). ovf pulses when the low n bits of count are all ones with cnt_en high, and count becomes 0 on the next cycle.
- R7: In pulse-pair mode (mode 2'b10), ovf pulses when count equals the period register (written with wr_prd) and cnt_en is high, and count becomes 0 on the next cycle.
- R8: When dbuf_en is 1, a cycle end (the ovf of R6 or R7) copies the staging buffer into the compare register on the same edge. The new value is used from the next count onward.
- R9: In interval mode (mode 2'b00 or 2'b11), no transfer ever occurs. Count runs as a full 8-bit counter, ovf pulses at count 255, and count returns to 0 after a match on a nonzero compare value.
- R10: When a buffered write and a transfer happen in the same cycle, the compare register takes the old buffer contents and the staging buffer keeps the new write data.
- R11: While cnt_en is low, count holds its value and neither match nor ovf pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable |
| mode | input | 2 | 00/11 interval, 01 pulse-width, 10 pulse-pair |
| pwm_sel | input | 2 | Pulse-width period exponent select (6,7,8) |
| dbuf_en | input | 1 | Staging (double-buffer) enable |
| wr_cmp | input | 1 | Write strobe for compare register / staging buffer |
| wr_prd | input | 1 | Write strobe for pulse-pair period register |
| wr_data | input | 8 | Write data |
| count | output | 8 | Current counter value |
| cmp_value | output | 8 | Compare register in use |
| match | output | 1 | Compare match strobe |
| ovf | output | 1 | Overflow / cycle-end strobe |

## Verification
The bench aims at a zero compare value. A design that compares literally would strobe match at count 0 instead of at the overflow. It runs the staging setup sequence in pulse-width and pulse-pair modes and checks that the compare value moves only at the cycle end. A design that loads the buffer early would change the match point part-way through a cycle. It puts a staging write on exactly the transfer cycle. A wrong priority there would either lose the new data or load it one cycle early. It also stages values in interval mode, where any transfer at all is an error, and pauses the enable to catch counters that drift or strobe while held.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER = 2'b00,
    MODE_PWM   = 2'b01,
    MODE_PPG   = 2'b10,
    MODE_ALT   = 2'b11
  } tmr_mode_e;

  // exponent chosen by the select code, clamped to the counter width
  function automatic int unsigned pwm_exp(input int unsigned sel,
                                          input int unsigned width);
    int unsigned e;
    e = width - 2 + sel;
    if (e > width) e = width;
    return e;
  endfunction
endpackage

// File: rtl/tmr_upcount.sv
module tmr_upcount #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (en)  cnt <= clr ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_evt.sv
module tmr_evt #(
  parameter int W    = 8,
  parameter int SELW = 2
) (
  input  logic [W-1:0]    cnt,
  input  logic [W-1:0]    cmp,
  input  logic [W-1:0]    prd,
  input  logic [1:0]      mode,
  input  logic [SELW-1:0] sel,
  input  logic            en,
  output logic            ovf,
  output logic            match,
  output logic            clr,
  output logic            cyc_end
);
  import tmr_pkg::*;

  function automatic logic [W-1:0] low_mask(input int unsigned nb);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i < nb);
    return m;
  endfunction

  function automatic logic low_ones(input logic [W-1:0] c,
                                    input int unsigned nb);
    return ((c | ~low_mask(nb)) == {W{1'b1}});
  endfunction

  logic pwm_end, ppg_end, full_wrap, ovf_raw, hit, is_timer;

  always_comb begin
    pwm_end   = low_ones(cnt, pwm_exp(int'(sel), W));
    ppg_end   = (cnt == prd);
    full_wrap = (cnt == {W{1'b1}});
    is_timer  = (mode == MODE_TIMER) || (mode == MODE_ALT);
    unique case (mode)
      MODE_PWM: ovf_raw = pwm_end;
      MODE_PPG: ovf_raw = ppg_end;
      default:  ovf_raw = full_wrap;
    endcase
    hit     = (cmp == '0) ? ovf_raw : (cnt == cmp);
    ovf     = en & ovf_raw;
    match   = en & hit;
    clr     = ovf | (is_timer & match);
    cyc_end = ovf & ~is_timer;
  end
endmodule

// File: rtl/tmr_cmpreg.sv
module tmr_cmpreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] data,
  input  logic         dbuf_en,
  input  logic         xfer,
  output logic [W-1:0] cmp,
  output logic [W-1:0] stage
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp   <= '0;
      stage <= '0;
    end else begin
      if (wr) stage <= data;
      if (wr && !dbuf_en) cmp <= data;
      else if (xfer)      cmp <= stage;
    end
  end
endmodule

// File: rtl/dbuf_cmp_timer.sv
module dbuf_cmp_timer #(
  parameter int W    = 8,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnt_en,
  input  logic [1:0]      mode,
  input  logic [SELW-1:0] pwm_sel,
  input  logic            dbuf_en,
  input  logic            wr_cmp,
  input  logic            wr_prd,
  input  logic [W-1:0]    wr_data,
  output logic [W-1:0]    count,
  output logic [W-1:0]    cmp_value,
  output logic            match,
  output logic            ovf
);
  logic [W-1:0] prd_q, buf_q;
  logic         cnt_clr, cyc_end, xfer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prd_q <= '1;
    else if (wr_prd) prd_q <= wr_data;
  end

  tmr_upcount #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cnt_en), .clr(cnt_clr), .cnt(count)
  );

  tmr_evt #(.W(W), .SELW(SELW)) u_evt (
    .cnt(count), .cmp(cmp_value), .prd(prd_q), .mode(mode), .sel(pwm_sel),
    .en(cnt_en), .ovf(ovf), .match(match), .clr(cnt_clr), .cyc_end(cyc_end)
  );

  assign xfer = dbuf_en & cyc_end;

  tmr_cmpreg #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr(wr_cmp), .data(wr_data),
    .dbuf_en(dbuf_en), .xfer(xfer), .cmp(cmp_value), .stage(buf_q)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic [1:0]   mode,
  input logic         dbuf_en,
  input logic         wr_cmp,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] count,
  input logic [W-1:0] cmp_value,
  input logic [W-1:0] buf_q,
  input logic         match,
  input logic         ovf,
  input logic         xfer
);
  a_r2_match_point: assert property (@(posedge clk) disable iff (!rst_n)
    (match && cmp_value != '0) |-> count == cmp_value);
  a_r3_zero_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (match && cmp_value == '0) |-> ovf);
  a_r4_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmp && !dbuf_en) |=> cmp_value == $past(wr_data));
  a_r5_staged_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dbuf_en && !xfer) |=> $stable(cmp_value));
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> count == '0);
  a_r8_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> cmp_value == $past(buf_q));
  a_r9_no_timer_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 || mode == 2'b11) |-> !xfer);
  a_r10_new_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && wr_cmp) |=> buf_q == $past(wr_data));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count));
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |-> !match && !ovf);
endmodule

bind dbuf_cmp_timer tmr_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode(mode), .dbuf_en(dbuf_en),
  .wr_cmp(wr_cmp), .wr_data(wr_data), .count(count), .cmp_value(cmp_value),
  .buf_q(buf_q), .match(match), .ovf(ovf), .xfer(xfer)
);

// File: tb/dbuf_cmp_timer_bench.sv
`timescale 1ns/100ps
module dbuf_cmp_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [1:0] pwm_sel = 2'b00;
  logic       dbuf_en = 1'b0;
  logic       wr_cmp = 1'b0;
  logic       wr_prd = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] count, cmp_value;
  logic       match, ovf;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int m_cnt = 0, m_cmp = 0, m_buf = 0, m_prd = 255;
  string cmp_tag = "R1";

  always #2.5 clk = ~clk;

  dbuf_cmp_timer u_dbuf_cmp_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode(mode), .pwm_sel(pwm_sel),
    .dbuf_en(dbuf_en), .wr_cmp(wr_cmp), .wr_prd(wr_prd), .wr_data(wr_data),
    .count(count), .cmp_value(cmp_value), .match(match), .ovf(ovf)
  );

  function automatic int period_of(input int sel);
    if (sel == 0) return 64;
    if (sel == 1) return 128;
    return 256;
  endfunction

  function automatic bit cycle_end(input int md, input int sel, input int c, input int p);
    if (md == 1) return (c % period_of(sel)) == period_of(sel) - 1;
    if (md == 2) return c == p;
    return c == 255;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    bit e_end, e_ovf, e_match, e_xfer, tmr;
    int md;
    #1;
    md    = int'(mode);
    tmr   = (md == 0 || md == 3);
    e_end = cycle_end(md, int'(pwm_sel), m_cnt, m_prd);
    e_ovf = cnt_en && e_end;
    e_match = cnt_en && ((m_cmp == 0) ? e_end : (m_cnt == m_cmp));
    check(count == m_cnt[7:0], !cnt_en ? "R11" : (md == 1 ? "R6" : (md == 2 ? "R7" : "R9")),
          "count", count, m_cnt);
    check(cmp_value == m_cmp[7:0], cmp_tag, "cmp_value", cmp_value, m_cmp);
    check(ovf == e_ovf, !cnt_en ? "R11" : (md == 1 ? "R6" : (md == 2 ? "R7" : "R9")),
          "ovf", ovf, e_ovf);
    check(match == e_match, !cnt_en ? "R11" : (m_cmp == 0 ? "R3" : "R2"),
          "match", match, e_match);
    e_xfer = e_ovf && dbuf_en && !tmr;
    @(posedge clk);
    if (cnt_en) m_cnt = (e_ovf || (tmr && e_match)) ? 0 : (m_cnt + 1) % 256;
    if (wr_cmp && !dbuf_en)      begin m_cmp = wr_data; cmp_tag = "R4"; end
    else if (e_xfer && wr_cmp)   begin m_cmp = m_buf;   cmp_tag = "R10"; end
    else if (e_xfer)             begin m_cmp = m_buf;   cmp_tag = "R8"; end
    else if (dbuf_en && tmr)     cmp_tag = "R9";
    else                         cmp_tag = "R5";
    if (wr_cmp) m_buf = wr_data;
    if (wr_prd) m_prd = wr_data;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic write_cmp(input int v);
    wr_cmp = 1'b1; wr_data = v[7:0];
    step();
    wr_cmp = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(count == 0 && cmp_value == 0, "R1", "count/cmp after reset",
          {count, cmp_value}, 0);
    check(match == 0 && ovf == 0, "R1", "strobes after reset", {match, ovf}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cnt_en = 1'b1;
    run(260);                       // R1: period all ones, compare 0 matches on wrap (R3)

    // R2/R9: interval mode with nonzero compare, cleared after match
    write_cmp(20);
    run(70);

    // R5/R8: staging setup in pulse-width mode, n = 6
    mode = 2'b01; pwm_sel = 2'd0;
    write_cmp(16);
    dbuf_en = 1'b1;
    write_cmp(48);
    run(140);

    // R10: staged write lands on the transfer cycle
    while (m_cnt != 63) step();
    write_cmp(34);
    run(70);

    // R7/R8: pulse-pair mode with period 40
    mode = 2'b10;
    wr_prd = 1'b1; wr_data = 8'd40; step(); wr_prd = 1'b0;
    write_cmp(0);                   // R3: zero compare in pulse-pair mode
    run(100);
    write_cmp(12);
    run(90);

    // R9: staging in interval mode never loads
    mode = 2'b00;
    write_cmp(99);
    run(300);

    // R11: enable paused
    cnt_en = 1'b0;
    run(10);
    cnt_en = 1'b1;

    // random phase
    for (int i = 0; i < 6000; i++) begin
      cnt_en = ($urandom % 10) != 0;
      if ($urandom % 250 == 0) mode = 2'($urandom % 4);
      if ($urandom % 250 == 0) pwm_sel = 2'($urandom % 4);
      if ($urandom % 150 == 0) dbuf_en = ~dbuf_en;
      wr_cmp = ($urandom % 40) == 0;
      wr_prd = ($urandom % 120) == 0;
      if (wr_prd) wr_data = 8'(8 + $urandom % 248);
      else        wr_data = ($urandom % 5 == 0) ? 8'd0 : 8'($urandom % 256);
      step();
    end
    wr_cmp = 1'b0; wr_prd = 1'b0;
    run(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule